// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block keeps recently used virtual-to-physical page translations so that most address translations avoid a walk of the in-memory page table. A request carries a virtual address and a load/store flag. The low bits of the address are the page offset and pass through unchanged. The bits just above the offset select one set, and the remaining upper bits form the tag. Both ways of that set are compared, and one cycle later the block reports one of three results: a hit with the physical address, a miss, or a protection fault.

On a miss, an external walker fetches the translation and returns it on the fill port. The block then writes it into the selected set. Each set keeps one least-recently-used bit, which picks the way to replace. Each entry also keeps a dirty bit, which a store hit sets, and a referenced bit, which any hit sets. A single-cycle flush drops every translation, for example on a context switch.

Defaults: 40-bit virtual address, 14-bit offset, 8-bit set index (256 sets, 512 entries), 18-bit tag, 22-bit physical page number and 36-bit physical address.

Top module: `xlat_tlb2`

## Requirements
- R1: Virtual address bits [OFS_W+IDX_W-1:OFS_W] select the set and the bits above them form the tag. A request in one cycle produces `rsp_valid` in the next cycle. With no request in a cycle, there is no response in the next cycle.
- R2: On a hit, `rsp_pa` is the stored page number joined above the unchanged request offset, and `rsp_rights` gives the stored access rights.
- R3: Every response raises exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault`. `rsp_miss` is raised when no valid way in the selected set holds the request tag.
- R4: A fill writes `fill_vpn` into the set given by its low IDX_W bits, using the upper bits as tag. The way is chosen in this order: a valid way already holding that tag, then an invalid way (way 0 before way 1), then the least-recently-used way.
- R5: Each set has one recency bit. A hit that does not fault, or a fill, makes the way it touched the most recently used.
- R6: Rights bit 0 permits loads and bit 1 permits stores. A matching entry whose rights forbid the operation gives `rsp_fault` with `rsp_pa` zero, and it changes no dirty, referenced or recency state.
- R7: A store hit sets the entry's dirty bit. `rsp_dirty` shows the dirty bit as it was before the access.
- R8: Any hit sets the entry's referenced bit. `rsp_ref` shows its value before the access. A fill clears the referenced bit and loads the dirty bit from `fill_dirty`.
- R9: A flush invalidates every entry within one cycle, and a lookup in the same cycle as a flush reports a miss.
- R10: A fill in the same cycle as a flush is discarded.
- R11: After reset every entry is invalid and no response is raised.
- R12: A lookup in the same cycle as a fill sees the contents from before the fill. The new entry is visible to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address to translate |
| req_store | input | 1 | 1 for store, 0 for load |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Fill entry present |
| fill_vpn | input | VA_W-OFS_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_ar | input | 2 | Access rights of the fill |
| fill_dirty | input | 1 | Initial dirty bit of the fill |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No translation, walker needed |
| rsp_fault | output | 1 | Rights forbid the operation |
| rsp_pa | output | PPN_W+OFS_W | Physical address |
| rsp_rights | output | 2 | Rights of the matching entry |
| rsp_dirty | output | 1 | Dirty bit before the access |
| rsp_ref | output | 1 | Referenced bit before the access |

## Verification
The bench builds the block with IDX_W=2, which gives four sets, and keeps the other widths at their defaults. With so few sets, a handful of fills to one set is enough to run through every stage of the way choice: empty way, existing tag, and recency victim. The full 24-bit tag still lets the same tag be placed in two sets, which checks that the set index takes part in matching. The default geometry differs only in its index width.

// File: rtl/xlat_tlb2_pkg.sv
package xlat_tlb2_pkg;

    // Access rights encoding: bit 0 grants loads, bit 1 grants stores
    typedef enum logic [1:0] {
        AR_NONE = 2'b00,
        AR_LD   = 2'b01,
        AR_ST   = 2'b10,
        AR_LDST = 2'b11
    } rights_e;

    function automatic logic rights_permit(input logic [1:0] ar, input logic is_store);
        return is_store ? ar[1] : ar[0];
    endfunction

endpackage

// File: rtl/xlat_tlb2_way.sv
module xlat_tlb2_way #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 18,
    parameter int PPN_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] a_idx,
    output logic             a_valid,
    output logic [TAG_W-1:0] a_tag,
    output logic [PPN_W-1:0] a_ppn,
    output logic [1:0]       a_ar,
    output logic             a_dirty,
    output logic             a_ref,
    input  logic [IDX_W-1:0] b_idx,
    output logic             b_valid,
    output logic [TAG_W-1:0] b_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_ar,
    input  logic             wr_dirty,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_store
);
    localparam int SETS = 1 << IDX_W;

    typedef struct packed {
        logic [SETS-1:0] valid;
        logic [SETS-1:0] dirty;
        logic [SETS-1:0] refd;
    } flags_t;

    flags_t fl_d, fl_q;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [PPN_W-1:0] ppn_q [SETS];
    logic [1:0]       ar_q  [SETS];

    always_comb begin
        fl_d = fl_q;
        if (touch_en) begin
            fl_d.refd[touch_idx] = 1'b1;
            if (touch_store) begin
                fl_d.dirty[touch_idx] = 1'b1;
            end
        end
        // a fill overrides a touch of the same entry
        if (wr_en) begin
            fl_d.valid[wr_idx] = 1'b1;
            fl_d.dirty[wr_idx] = wr_dirty;
            fl_d.refd[wr_idx]  = 1'b0;
        end
        if (flush) begin
            fl_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            ppn_q[wr_idx] <= wr_ppn;
            ar_q[wr_idx]  <= wr_ar;
        end
    end

    assign a_valid = fl_q.valid[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_ppn   = ppn_q[a_idx];
    assign a_ar    = ar_q[a_idx];
    assign a_dirty = fl_q.dirty[a_idx];
    assign a_ref   = fl_q.refd[a_idx];
    assign b_valid = fl_q.valid[b_idx];
    assign b_tag   = tag_q[b_idx];

endmodule

// File: rtl/xlat_tlb2_lru.sv
module xlat_tlb2_lru #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_lru
);
    localparam int SETS = 1 << IDX_W;

    // bit per set names the least recently used way
    logic [SETS-1:0] lru_d, lru_q;

    always_comb begin
        lru_d = lru_q;
        if (hit_en) begin
            lru_d[hit_idx] = ~hit_way;
        end
        if (fill_en) begin
            lru_d[fill_idx] = ~fill_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            lru_q <= lru_d;
        end
    end

    assign rd_lru = lru_q[rd_idx];

endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2 #(
    parameter int VA_W  = 40,
    parameter int OFS_W = 14,
    parameter int IDX_W = 8,
    parameter int PPN_W = 22
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_va,
    input  logic                   req_store,
    input  logic                   flush,
    input  logic                   fill_valid,
    input  logic [VA_W-OFS_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic [1:0]             fill_ar,
    input  logic                   fill_dirty,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic                   rsp_fault,
    output logic [PPN_W+OFS_W-1:0] rsp_pa,
    output logic [1:0]             rsp_rights,
    output logic                   rsp_dirty,
    output logic                   rsp_ref
);
    import xlat_tlb2_pkg::*;

    localparam int VPN_W = VA_W - OFS_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PA_W  = PPN_W + OFS_W;
    localparam int WAYS  = 2;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic [PA_W-1:0] pa;
        logic [1:0]      ar;
        logic            dirty;
        logic            refd;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [IDX_W-1:0] req_idx, fill_idx;
    logic [TAG_W-1:0] req_tag, fill_tag;
    logic [OFS_W-1:0] req_ofs;

    logic             a_valid [WAYS];
    logic [TAG_W-1:0] a_tag   [WAYS];
    logic [PPN_W-1:0] a_ppn   [WAYS];
    logic [1:0]       a_ar    [WAYS];
    logic             a_dirty [WAYS];
    logic             a_ref   [WAYS];
    logic             b_valid [WAYS];
    logic [TAG_W-1:0] b_tag   [WAYS];
    logic [WAYS-1:0]  match, fmatch, wr_sel;

    logic             lookup, any_match, hit_way, permit, touch_en;
    logic             fill_go, victim, set_lru;
    logic [PPN_W-1:0] sel_ppn;
    logic [1:0]       sel_ar;

    assign req_ofs  = req_va[OFS_W-1:0];
    assign req_idx  = req_va[OFS_W +: IDX_W];
    assign req_tag  = req_va[OFS_W+IDX_W +: TAG_W];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[IDX_W +: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        xlat_tlb2_way #(
            .IDX_W(IDX_W),
            .TAG_W(TAG_W),
            .PPN_W(PPN_W)
        ) i_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .a_idx      (req_idx),
            .a_valid    (a_valid[w]),
            .a_tag      (a_tag[w]),
            .a_ppn      (a_ppn[w]),
            .a_ar       (a_ar[w]),
            .a_dirty    (a_dirty[w]),
            .a_ref      (a_ref[w]),
            .b_idx      (fill_idx),
            .b_valid    (b_valid[w]),
            .b_tag      (b_tag[w]),
            .wr_en      (wr_sel[w]),
            .wr_idx     (fill_idx),
            .wr_tag     (fill_tag),
            .wr_ppn     (fill_ppn),
            .wr_ar      (fill_ar),
            .wr_dirty   (fill_dirty),
            .touch_en   (touch_en && (hit_way == 1'(w))),
            .touch_idx  (req_idx),
            .touch_store(req_store)
        );
        assign match[w]  = a_valid[w] && (a_tag[w] == req_tag);
        assign fmatch[w] = b_valid[w] && (b_tag[w] == fill_tag);
        assign wr_sel[w] = fill_go && (victim == 1'(w));
    end

    xlat_tlb2_lru #(
        .IDX_W(IDX_W)
    ) i_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_en  (touch_en),
        .hit_idx (req_idx),
        .hit_way (hit_way),
        .fill_en (fill_go),
        .fill_idx(fill_idx),
        .fill_way(victim),
        .rd_idx  (fill_idx),
        .rd_lru  (set_lru)
    );

    always_comb begin
        lookup    = req_valid && !flush;
        any_match = |match;
        hit_way   = match[1];
        sel_ppn   = hit_way ? a_ppn[1] : a_ppn[0];
        sel_ar    = hit_way ? a_ar[1] : a_ar[0];
        permit    = rights_permit(sel_ar, req_store);
        touch_en  = lookup && any_match && permit;

        // fill way choice: same tag, then empty way, then recency victim
        fill_go = fill_valid && !flush;
        if (fmatch[0])        victim = 1'b0;
        else if (fmatch[1])   victim = 1'b1;
        else if (!b_valid[0]) victim = 1'b0;
        else if (!b_valid[1]) victim = 1'b1;
        else                  victim = set_lru;

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (lookup && any_match) begin
                rsp_d.ar = sel_ar;
                if (permit) begin
                    rsp_d.hit   = 1'b1;
                    rsp_d.pa    = {sel_ppn, req_ofs};
                    rsp_d.dirty = hit_way ? a_dirty[1] : a_dirty[0];
                    rsp_d.refd  = hit_way ? a_ref[1] : a_ref[0];
                end else begin
                    rsp_d.fault = 1'b1;
                end
            end else begin
                rsp_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_miss   = rsp_q.miss;
    assign rsp_fault  = rsp_q.fault;
    assign rsp_pa     = rsp_q.pa;
    assign rsp_rights = rsp_q.ar;
    assign rsp_dirty  = rsp_q.dirty;
    assign rsp_ref    = rsp_q.refd;

endmodule

// File: rtl/xlat_tlb2_chk.sv
module xlat_tlb2_chk #(
    parameter int VA_W  = 40,
    parameter int OFS_W = 14,
    parameter int PA_W  = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_store,
    input logic            flush,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa,
    input logic [1:0]      rsp_rights
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    // R3
    quiet_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    // R2
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0])));

    // R6
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pa == '0));

    // R6
    store_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(req_store)) |-> rsp_rights[1]);

    // R9
    flush_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flush) |=> rsp_miss);

    // R9
    after_flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && req_valid) |=> rsp_miss);

endmodule

bind xlat_tlb2 xlat_tlb2_chk #(
    .VA_W (VA_W),
    .OFS_W(OFS_W),
    .PA_W (PPN_W + OFS_W)
) i_xlat_tlb2_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_va    (req_va),
    .req_store (req_store),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa),
    .rsp_rights(rsp_rights)
);

// File: tb/test_xlat_tlb2.sv
`timescale 1ns/1ps
module test_xlat_tlb2;
    localparam int VA_W  = 40;
    localparam int OFS_W = 14;
    localparam int IDX_W = 2;
    localparam int PPN_W = 22;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PA_W  = PPN_W + OFS_W;

    localparam logic [1:0] K_NONE = 2'd0, K_HIT = 2'd1, K_MISS = 2'd2, K_FLT = 2'd3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0, req_store = 1'b0, flush = 1'b0;
    logic [VA_W-1:0]  req_va = '0;
    logic             fill_valid = 1'b0, fill_dirty = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [1:0]       fill_ar = '0;
    logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref;
    logic [PA_W-1:0]  rsp_pa;
    logic [1:0]       rsp_rights;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlat_tlb2 #(
        .VA_W(VA_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .PPN_W(PPN_W)
    ) i_xlat_tlb2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_store(req_store), .flush(flush), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_ar(fill_ar),
        .fill_dirty(fill_dirty), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_rights(rsp_rights), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
    );

    // one operation: fill row or lookup row with its expected response
    typedef struct packed {
        logic        fill;
        logic [15:0] tag;
        logic [1:0]  idx;
        logic [13:0] ofs;
        logic        st;
        logic [21:0] ppn;
        logic [1:0]  ar;
        logic        fd;
        logic [1:0]  kind;
        logic        dirty;
        logic        refd;
    } vec_t;

    // rights: 2'b01 load only, 2'b10 store only, 2'b11 both
    localparam vec_t TBL [23] = '{
        '{1'b0, 16'h5, 2'd1, 14'h0010, 1'b0, 22'h0,   2'd0, 1'b0, K_MISS, 1'b0, 1'b0}, // R3 empty
        '{1'b1, 16'h5, 2'd1, 14'h0,    1'b0, 22'h111, 2'd3, 1'b0, K_NONE, 1'b0, 1'b0}, // R4 fill
        '{1'b0, 16'h5, 2'd1, 14'h2AB,  1'b0, 22'h111, 2'd3, 1'b0, K_HIT,  1'b0, 1'b0}, // R2
        '{1'b0, 16'h5, 2'd1, 14'h3FFF, 1'b0, 22'h111, 2'd3, 1'b0, K_HIT,  1'b0, 1'b1}, // R8
        '{1'b0, 16'h5, 2'd1, 14'h0,    1'b1, 22'h111, 2'd3, 1'b0, K_HIT,  1'b0, 1'b1}, // R7 store
        '{1'b0, 16'h5, 2'd1, 14'h1234, 1'b0, 22'h111, 2'd3, 1'b0, K_HIT,  1'b1, 1'b1}, // R7 dirty
        '{1'b1, 16'h6, 2'd1, 14'h0,    1'b0, 22'h222, 2'd1, 1'b0, K_NONE, 1'b0, 1'b0}, // R4 empty way
        '{1'b0, 16'h6, 2'd1, 14'h0004, 1'b1, 22'h0,   2'd1, 1'b0, K_FLT,  1'b0, 1'b0}, // R6
        '{1'b0, 16'h6, 2'd1, 14'h0008, 1'b0, 22'h222, 2'd1, 1'b0, K_HIT,  1'b0, 1'b0}, // R6 no touch
        '{1'b1, 16'h7, 2'd1, 14'h0,    1'b0, 22'h333, 2'd3, 1'b0, K_NONE, 1'b0, 1'b0}, // R5 evict tag 5
        '{1'b0, 16'h5, 2'd1, 14'h0,    1'b0, 22'h0,   2'd0, 1'b0, K_MISS, 1'b0, 1'b0}, // R5
        '{1'b0, 16'h6, 2'd1, 14'h0,    1'b0, 22'h222, 2'd1, 1'b0, K_HIT,  1'b0, 1'b1}, // R5
        '{1'b0, 16'h7, 2'd1, 14'h0,    1'b0, 22'h333, 2'd3, 1'b0, K_HIT,  1'b0, 1'b0}, // R5
        '{1'b1, 16'h8, 2'd1, 14'h0,    1'b0, 22'h444, 2'd3, 1'b1, K_NONE, 1'b0, 1'b0}, // R5 evict tag 6
        '{1'b0, 16'h6, 2'd1, 14'h0,    1'b0, 22'h0,   2'd0, 1'b0, K_MISS, 1'b0, 1'b0}, // R5
        '{1'b0, 16'h8, 2'd1, 14'h0100, 1'b0, 22'h444, 2'd3, 1'b0, K_HIT,  1'b1, 1'b0}, // R8 fill dirty
        '{1'b1, 16'h7, 2'd1, 14'h0,    1'b0, 22'h555, 2'd2, 1'b0, K_NONE, 1'b0, 1'b0}, // R4 same tag
        '{1'b0, 16'h7, 2'd1, 14'h0,    1'b0, 22'h0,   2'd2, 1'b0, K_FLT,  1'b0, 1'b0}, // R6 store only
        '{1'b0, 16'h7, 2'd1, 14'h0042, 1'b1, 22'h555, 2'd2, 1'b0, K_HIT,  1'b0, 1'b0}, // R4 R8
        '{1'b0, 16'h8, 2'd2, 14'h0,    1'b0, 22'h0,   2'd0, 1'b0, K_MISS, 1'b0, 1'b0}, // R1 other set
        '{1'b1, 16'h9, 2'd2, 14'h0,    1'b0, 22'h666, 2'd3, 1'b0, K_NONE, 1'b0, 1'b0}, // R1
        '{1'b0, 16'h9, 2'd1, 14'h0,    1'b0, 22'h0,   2'd0, 1'b0, K_MISS, 1'b0, 1'b0}, // R1
        '{1'b0, 16'h9, 2'd2, 14'h0777, 1'b0, 22'h666, 2'd3, 1'b0, K_HIT,  1'b0, 1'b0}  // R1 R2
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid  = !v.fill;
        fill_valid = v.fill;
        req_va     = {TAG_W'(v.tag), v.idx, v.ofs};
        req_store  = v.st;
        fill_vpn   = {TAG_W'(v.tag), v.idx};
        fill_ppn   = v.ppn;
        fill_ar    = v.ar;
        fill_dirty = v.fd;
    endtask

    task automatic idle();
        req_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0; req_store = 1'b0;
    endtask

    task automatic check_rsp(input vec_t v);
        logic [2:0] exp_flags;
        if (v.kind == K_NONE) begin
            chk(rsp_valid == 1'b0, "R1 idle", 64'(rsp_valid), 64'd0);
            return;
        end
        exp_flags = (v.kind == K_HIT) ? 3'b100 : (v.kind == K_MISS) ? 3'b010 : 3'b001;
        chk(rsp_valid == 1'b1, "R1 valid", 64'(rsp_valid), 64'd1);
        chk({rsp_hit, rsp_miss, rsp_fault} == exp_flags, "R3 outcome",
            64'({rsp_hit, rsp_miss, rsp_fault}), 64'(exp_flags));
        if (v.kind == K_HIT) begin
            chk(rsp_pa == {v.ppn, v.ofs}, "R2 address", 64'(rsp_pa), 64'({v.ppn, v.ofs}));
            chk(rsp_rights == v.ar, "R2 rights", 64'(rsp_rights), 64'(v.ar));
            chk(rsp_dirty == v.dirty, "R7 dirty", 64'(rsp_dirty), 64'(v.dirty));
            chk(rsp_ref == v.refd, "R8 referenced", 64'(rsp_ref), 64'(v.refd));
        end
        if (v.kind == K_FLT) begin
            chk(rsp_pa == '0, "R6 fault address", 64'(rsp_pa), 64'd0);
        end
    endtask

    task automatic lookup_expect(input logic [15:0] tag, input logic [1:0] idx,
                                 input logic exp_hit, input logic [21:0] ppn, input string req);
        req_valid = 1'b1; req_store = 1'b0;
        req_va = {TAG_W'(tag), idx, 14'h0055};
        @(negedge clk);
        idle();
        chk(rsp_hit == exp_hit && rsp_miss == !exp_hit, req,
            64'({rsp_hit, rsp_miss}), 64'({exp_hit, !exp_hit}));
        if (exp_hit) begin
            chk(rsp_pa == {ppn, 14'h0055}, req, 64'(rsp_pa), 64'({ppn, 14'h0055}));
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: no response while and right after reset
        chk(rsp_valid == 1'b0, "R11 reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 after reset", 64'(rsp_valid), 64'd0);
        lookup_expect(16'h5, 2'd1, 1'b0, 22'h0, "R11 empty miss");

        for (int i = 0; i < 23; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            idle();
            check_rsp(TBL[i]);
        end

        // R12: fill and lookup of the same page together
        fill_valid = 1'b1; fill_vpn = {TAG_W'(16'hA), 2'd0}; fill_ppn = 22'h0AAA;
        fill_ar = 2'b11; fill_dirty = 1'b0;
        req_valid = 1'b1; req_va = {TAG_W'(16'hA), 2'd0, 14'h0055};
        @(negedge clk);
        idle();
        chk(rsp_miss == 1'b1, "R12 same cycle", 64'(rsp_miss), 64'd1);
        lookup_expect(16'hA, 2'd0, 1'b1, 22'h0AAA, "R12 next request");

        // R9: lookup during flush misses, and entries are gone
        req_valid = 1'b1; flush = 1'b1; req_va = {TAG_W'(16'hA), 2'd0, 14'h0055};
        @(negedge clk);
        idle();
        chk(rsp_miss == 1'b1, "R9 lookup in flush", 64'(rsp_miss), 64'd1);
        lookup_expect(16'hA, 2'd0, 1'b0, 22'h0, "R9 flushed set 0");
        lookup_expect(16'h9, 2'd2, 1'b0, 22'h0, "R9 flushed set 2");
        lookup_expect(16'h8, 2'd1, 1'b0, 22'h0, "R9 flushed set 1");

        // R10: fill together with flush is dropped
        fill_valid = 1'b1; flush = 1'b1; fill_vpn = {TAG_W'(16'hB), 2'd3};
        fill_ppn = 22'h0BBB; fill_ar = 2'b11;
        @(negedge clk);
        idle();
        lookup_expect(16'hB, 2'd3, 1'b0, 22'h0, "R10 fill dropped");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule